// File: doc/BRIEF.md
# Parallel Port Control Register Unit

This block is the processor-side register file of a 24-line parallel I/O controller with three 8-bit ports. It decodes a 2-bit address together with active-low select, read and write strobes. Port A and port B each have one data register. Port C is split into an upper and a lower half, each owned by one of two control groups. One control address accepts two kinds of command: a mode-set word that configures both groups, and a single-bit command that sets or clears one port C line.

The unit stores the group modes, the direction bits, the port A, B and C output latches and three interrupt-enable flags. From the modes it works out the role of every port C line: general I/O, handshake output, or strobe/acknowledge input. It drives per-line output enables and passes the modes and flags to separate handshake channels. Bus tri-state is represented by an output-enable flag beside the read data.

Writes are committed on the rising edge of the write strobe. That edge is detected in the system clock domain after a synchroniser. Reads are combinational from the strobes.

Top module: `pio_regfile`

## Requirements
- R1: Read address 0 returns port A, 1 port B, 2 port C and 3 the control word. `dout_oe` is 1 exactly when `cs_n`=0, `rd_n`=0 and `wr_n`=1.
- R2: After reset the control word reads 8'h9B (both groups mode 0, every port an input). `pa_oe`, `pb_oe` and all of `pc_oe` are 0. The latches and the three enable flags are 0.
- R3: A control write with bit 7 = 1 is a mode set. Bits 6:5 are the group A mode (00 mode 0, 01 mode 1, 1x mode 2) and bit 2 is the group B mode. Direction bits are 1 = input: bit 4 port A, bit 3 port C upper, bit 1 port B, bit 0 port C lower. The word reads back with bit 7 = 1 and bits 6:0 as written. In mode 0 `pa_oe`=!bit4, `pb_oe`=!bit1, `pc_oe[7:4]`=!bit3 and `pc_oe[3:0]`=!bit0. `pa_oe` is also 0 in mode 2.
- R4: A mode set clears the port A, B and C latches and all three enable flags.
- R5: A write to address 0 or 1 loads that port's latch. A read of a port that is an output returns the latch; a read of an input port returns the pin value.
- R6: A write to address 2 changes only port C lines that are general outputs of a group in mode 0. PC3 belongs to the lower group when group A is in mode 0.
- R7: A control write with bit 7 = 0 is a bit command. Bits 3:1 give the line and bit 0 gives the value; bits 6:4 are ignored. It changes the latch of any port C line that is an output, including handshake outputs. It leaves input lines unchanged.
- R8: A bit command aimed at a strobe/acknowledge input changes a flag instead of a pin. PC2 sets the group B flag `inte_b`, PC4 sets `inte_a2` and PC6 sets `inte_a1`.
- R9: A port C read returns the flag at each strobe/acknowledge position, the latch at each general output, and `pc_in` at every other position.
- R10: Line roles in modes 1 and 2 follow this map. Group B mode 1: PC0 and PC1 are outputs and PC2 is an input. Group A mode 1 input: PC3 and PC5 are outputs, PC4 is an input, PC7:6 are I/O. Group A mode 1 output: PC3 and PC7 are outputs, PC6 is an input, PC5:4 are I/O. Group A mode 2: PC3, PC5 and PC7 are outputs, PC4 and PC6 are inputs.
- R11: A write has no effect while `wr_n` stays low, and none when `cs_n` was high throughout the low phase. The write is visible after the third rising clock edge following the rise of `wr_n`, and not after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 2 | Register address |
| din | input | 8 | Write data from the processor bus |
| dout | output | 8 | Read data to the processor bus |
| dout_oe | output | 1 | Read data drive enable |
| pa_in | input | 8 | Port A pin values |
| pb_in | input | 8 | Port B pin values |
| pc_in | input | 8 | Port C pin and status values |
| pa_out | output | 8 | Port A output latch |
| pb_out | output | 8 | Port B output latch |
| pc_out | output | 8 | Port C output latch |
| pa_oe | output | 1 | Port A drive enable |
| pb_oe | output | 1 | Port B drive enable |
| pc_oe | output | 8 | Port C per-line drive enable |
| grp_a_mode | output | 2 | Group A mode to the handshake channels |
| grp_b_mode | output | 1 | Group B mode to the handshake channels |
| inte_a1 | output | 1 | Group A output-side interrupt enable |
| inte_a2 | output | 1 | Group A input-side interrupt enable |
| inte_b | output | 1 | Group B interrupt enable |

## Verification
Two functions can coincide here: a port C status read and the delayed commit of a bit command. A write commit lands several clock edges after `wr_n` rises, so a read started right after a write is still open when the commit arrives. The bench provokes this by issuing a bit command at PC2 while group B is in mode 1. It then drops `rd_n` on port C in the same cycle that `wr_n` rises. Bit 2 of the read data must show the old flag one edge later and the new flag after the third edge.

// File: rtl/pio_pkg.sv
package pio_pkg;
   typedef enum logic [1:0] {
      SEL_A   = 2'd0,
      SEL_B   = 2'd1,
      SEL_C   = 2'd2,
      SEL_CTL = 2'd3
   } pio_sel_e;

   // field order matches the control word bits 6:0
   typedef struct packed {
      logic [1:0] a_mode;
      logic       a_in;
      logic       cu_in;
      logic       b_mode;
      logic       b_in;
      logic       cl_in;
   } pio_cfg_t;

   localparam pio_cfg_t CFG_RESET = 7'b00_1_1_0_1_1;
endpackage

// File: rtl/pio_wr_sync.sv
module pio_wr_sync #(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_n,
   input  logic              cs_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              commit,
   output logic [ADDR_W-1:0] c_addr,
   output logic [DATA_W-1:0] c_data
);
   localparam int MSB = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pio_wr_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sh;
   logic                   prev;
   logic                   hold_v;
   logic                   rise;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         sh   <= '1;
         prev <= 1'b1;
      end else begin
         sh   <= {sh[SYNC_STAGES-2:0], wr_n};
         prev <= sh[MSB];
      end
   end

   assign rise = sh[MSB] & ~prev;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         hold_v <= 1'b0;
         c_addr <= '0;
         c_data <= '0;
      end else if (!wr_n && !cs_n) begin
         hold_v <= 1'b1;
         c_addr <= addr;
         c_data <= din;
      end else if (rise) begin
         hold_v <= 1'b0;
      end
   end

   assign commit = rise & hold_v;

   // R11
   single_commit_chk: assert property (@(posedge clk) disable iff (rst)
      commit |=> !commit);
endmodule

// File: rtl/pio_cfg.sv
module pio_cfg
   import pio_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              commit,
   input  logic [ADDR_W-1:0] c_addr,
   input  logic [DATA_W-1:0] c_data,
   output pio_cfg_t          cfg,
   output logic              mode_wr,
   output logic              bsr_wr,
   output logic [2:0]        bsr_idx,
   output logic              bsr_val,
   output logic              inte_a1,
   output logic              inte_a2,
   output logic              inte_b,
   output logic [7:0]        pin_hs_in,
   output logic [7:0]        pin_hs_out,
   output logic [7:0]        pin_io,
   output logic [7:0]        pin_io_in,
   output logic [7:0]        pin_m0
);
   logic ctl_hit;

   assign ctl_hit = commit && (c_addr == ADDR_W'(SEL_CTL));
   assign mode_wr = ctl_hit &&  c_data[7];
   assign bsr_wr  = ctl_hit && !c_data[7];
   assign bsr_idx = c_data[3:1];
   assign bsr_val = c_data[0];

   always_ff @(posedge clk or posedge rst) begin
      if (rst)          cfg <= CFG_RESET;
      else if (mode_wr) cfg <= pio_cfg_t'(c_data[6:0]);
   end

   // per-line role of port C derived from both group modes
   always_comb begin
      pin_hs_in  = '0;
      pin_hs_out = '0;
      pin_io     = '0;
      pin_io_in  = '0;
      pin_m0     = '0;
      if (!cfg.b_mode) begin
         pin_io[2:0]    = 3'b111;
         pin_io_in[2:0] = {3{cfg.cl_in}};
         pin_m0[2:0]    = 3'b111;
      end else begin
         pin_hs_out[1:0] = 2'b11;
         pin_hs_in[2]    = 1'b1;
      end
      case (cfg.a_mode)
         2'b00: begin
            pin_io[7:3]    = 5'b11111;
            pin_io_in[7:4] = {4{cfg.cu_in}};
            pin_io_in[3]   = cfg.cl_in;
            pin_m0[7:4]    = 4'b1111;
            pin_m0[3]      = !cfg.b_mode;
         end
         2'b01: begin
            pin_hs_out[3] = 1'b1;
            if (cfg.a_in) begin
               pin_hs_in[4]   = 1'b1;
               pin_hs_out[5]  = 1'b1;
               pin_io[7:6]    = 2'b11;
               pin_io_in[7:6] = {2{cfg.cu_in}};
            end else begin
               pin_hs_out[7]  = 1'b1;
               pin_hs_in[6]   = 1'b1;
               pin_io[5:4]    = 2'b11;
               pin_io_in[5:4] = {2{cfg.cu_in}};
            end
         end
         default: begin
            pin_hs_out[3] = 1'b1;
            pin_hs_in[4]  = 1'b1;
            pin_hs_out[5] = 1'b1;
            pin_hs_in[6]  = 1'b1;
            pin_hs_out[7] = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         inte_a1 <= 1'b0;
         inte_a2 <= 1'b0;
         inte_b  <= 1'b0;
      end else if (mode_wr) begin
         inte_a1 <= 1'b0;
         inte_a2 <= 1'b0;
         inte_b  <= 1'b0;
      end else if (bsr_wr && pin_hs_in[bsr_idx]) begin
         case (bsr_idx)
            3'd2:    inte_b  <= bsr_val;
            3'd4:    inte_a2 <= bsr_val;
            3'd6:    inte_a1 <= bsr_val;
            default: ;
         endcase
      end
   end

   // R4
   mode_clears_flags_chk: assert property (@(posedge clk) disable iff (rst)
      mode_wr |=> (!inte_a1 && !inte_a2 && !inte_b));
   // R3
   cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !mode_wr |=> $stable(cfg));
endmodule

// File: rtl/pio_portc.sv
module pio_portc #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_wr,
   input  logic              direct_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              bsr_wr,
   input  logic [2:0]        bsr_idx,
   input  logic              bsr_val,
   input  logic [7:0]        pin_hs_in,
   input  logic [7:0]        pin_hs_out,
   input  logic [7:0]        pin_io,
   input  logic [7:0]        pin_io_in,
   input  logic [7:0]        pin_m0,
   input  logic              inte_a1,
   input  logic              inte_a2,
   input  logic              inte_b,
   input  logic [7:0]        pc_in,
   output logic [7:0]        pc_latch,
   output logic [7:0]        pc_oe,
   output logic [7:0]        pc_rd
);
   logic [7:0] flag_at;
   logic [7:0] io_out;

   assign flag_at = {1'b0, inte_a1, 1'b0, inte_a2, 1'b0, inte_b, 2'b00};
   assign io_out  = pin_io & ~pin_io_in;

   for (genvar i = 0; i < 8; i++) begin : g_line
      localparam logic [2:0] IDX = 3'(i);
      assign pc_oe[i] = pin_hs_out[i] | io_out[i];
      always_ff @(posedge clk or posedge rst) begin
         if (rst)                                     pc_latch[i] <= 1'b0;
         else if (mode_wr)                            pc_latch[i] <= 1'b0;
         else if (direct_wr && io_out[i] && pin_m0[i]) pc_latch[i] <= wdata[i];
         else if (bsr_wr && bsr_idx == IDX && pc_oe[i]) pc_latch[i] <= bsr_val;
      end
      assign pc_rd[i] = pin_hs_in[i] ? flag_at[i]
                      : io_out[i]    ? pc_latch[i]
                      :                pc_in[i];
   end

   // R6
   latch_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !(mode_wr || direct_wr || bsr_wr) |=> $stable(pc_latch));
   // R8
   flag_cmd_no_pin_chk: assert property (@(posedge clk) disable iff (rst)
      (bsr_wr && pin_hs_in[bsr_idx]) |=> $stable(pc_latch));
endmodule

// File: rtl/pio_regfile.sv
module pio_regfile
   import pio_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe,
   input  logic [DATA_W-1:0] pa_in,
   input  logic [DATA_W-1:0] pb_in,
   input  logic [DATA_W-1:0] pc_in,
   output logic [DATA_W-1:0] pa_out,
   output logic [DATA_W-1:0] pb_out,
   output logic [DATA_W-1:0] pc_out,
   output logic              pa_oe,
   output logic              pb_oe,
   output logic [DATA_W-1:0] pc_oe,
   output logic [1:0]        grp_a_mode,
   output logic              grp_b_mode,
   output logic              inte_a1,
   output logic              inte_a2,
   output logic              inte_b
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("pio_regfile: port C line roles need DATA_W == 8");
      end
      if (ADDR_W != 2) begin : g_bad_addr
         $error("pio_regfile: four registers need ADDR_W == 2");
      end
   endgenerate

   logic              commit;
   logic [ADDR_W-1:0] c_addr;
   logic [DATA_W-1:0] c_data;
   pio_cfg_t          cfg;
   logic              mode_wr, bsr_wr, bsr_val;
   logic [2:0]        bsr_idx;
   logic [7:0]        pin_hs_in, pin_hs_out, pin_io, pin_io_in, pin_m0;
   logic [7:0]        pc_rd;
   logic [DATA_W-1:0] pa_latch, pb_latch;

   pio_wr_sync #(.SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
      .clk(clk), .rst(rst), .wr_n(wr_n), .cs_n(cs_n), .addr(addr), .din(din),
      .commit(commit), .c_addr(c_addr), .c_data(c_data));

   pio_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
      .clk(clk), .rst(rst), .commit(commit), .c_addr(c_addr), .c_data(c_data),
      .cfg(cfg), .mode_wr(mode_wr), .bsr_wr(bsr_wr), .bsr_idx(bsr_idx),
      .bsr_val(bsr_val), .inte_a1(inte_a1), .inte_a2(inte_a2), .inte_b(inte_b),
      .pin_hs_in(pin_hs_in), .pin_hs_out(pin_hs_out), .pin_io(pin_io),
      .pin_io_in(pin_io_in), .pin_m0(pin_m0));

   pio_portc #(.DATA_W(DATA_W)) u_portc (
      .clk(clk), .rst(rst), .mode_wr(mode_wr),
      .direct_wr(commit && (c_addr == ADDR_W'(SEL_C))), .wdata(c_data),
      .bsr_wr(bsr_wr), .bsr_idx(bsr_idx), .bsr_val(bsr_val),
      .pin_hs_in(pin_hs_in), .pin_hs_out(pin_hs_out), .pin_io(pin_io),
      .pin_io_in(pin_io_in), .pin_m0(pin_m0), .inte_a1(inte_a1),
      .inte_a2(inte_a2), .inte_b(inte_b), .pc_in(pc_in),
      .pc_latch(pc_out), .pc_oe(pc_oe), .pc_rd(pc_rd));

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         pa_latch <= '0;
         pb_latch <= '0;
      end else if (mode_wr) begin
         pa_latch <= '0;
         pb_latch <= '0;
      end else if (commit && c_addr == ADDR_W'(SEL_A)) begin
         pa_latch <= c_data;
      end else if (commit && c_addr == ADDR_W'(SEL_B)) begin
         pb_latch <= c_data;
      end
   end

   assign pa_oe      = !cfg.a_in && !cfg.a_mode[1];
   assign pb_oe      = !cfg.b_in;
   assign pa_out     = pa_latch;
   assign pb_out     = pb_latch;
   assign grp_a_mode = cfg.a_mode;
   assign grp_b_mode = cfg.b_mode;

   always_comb begin
      case (pio_sel_e'(addr))
         SEL_A:   dout = pa_oe ? pa_latch : pa_in;
         SEL_B:   dout = pb_oe ? pb_latch : pb_in;
         SEL_C:   dout = pc_rd;
         default: dout = {1'b1, cfg};
      endcase
   end

   assign dout_oe = !cs_n && !rd_n && wr_n;

   // R4
   mode_clears_ports_chk: assert property (@(posedge clk) disable iff (rst)
      mode_wr |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));
endmodule

// File: tb/pio_regfile_tb.sv
module pio_regfile_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 0, rst = 1;
   logic cs_n = 1, rd_n = 1, wr_n = 1;
   logic [1:0] addr = 0;
   logic [7:0] din = 0, pa_in = 0, pb_in = 0, pc_in = 0;
   logic [7:0] dout, pa_out, pb_out, pc_out, pc_oe;
   logic dout_oe, pa_oe, pb_oe, grp_b_mode, inte_a1, inte_a2, inte_b;
   logic [1:0] grp_a_mode;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pio_regfile u_dut (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
      .din(din), .dout(dout), .dout_oe(dout_oe), .pa_in(pa_in), .pb_in(pb_in),
      .pc_in(pc_in), .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
      .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe), .grp_a_mode(grp_a_mode),
      .grp_b_mode(grp_b_mode), .inte_a1(inte_a1), .inte_a2(inte_a2), .inte_b(inte_b));

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; din = d; cs_n = 0; wr_n = 0;
      repeat (2) @(negedge clk);
      wr_n = 1;
      @(negedge clk); cs_n = 1;
      repeat (3) @(negedge clk);
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; cs_n = 0; rd_n = 0;
      #1 d = dout;
      chk("R1 oe during read", {7'd0, dout_oe}, 8'd1);
      @(negedge clk); rd_n = 1; cs_n = 1;
   endtask

   // role masks from the R10 map, expressed per mode
   task automatic roles(input logic [6:0] c, output logic [7:0] hsin, output logic [7:0] oe,
                        output logic [7:0] wmask, output logic [7:0] ioout);
      logic [7:0] hsout, io, dirin, m0;
      hsout = 0; hsin = 0; io = 0; m0 = 0;
      if (c[2]) begin hsout |= 8'h03; hsin |= 8'h04; end
      else      begin io |= 8'h07; m0 |= 8'h07; end
      case (c[6:5])
         2'b00: begin io |= 8'hF8; m0 |= 8'hF0; if (!c[2]) m0 |= 8'h08; end
         2'b01: if (c[4]) begin hsout |= 8'h28; hsin |= 8'h10; io |= 8'hC0; end
                else      begin hsout |= 8'h88; hsin |= 8'h40; io |= 8'h30; end
         default: begin hsout |= 8'hA8; hsin |= 8'h50; end
      endcase
      dirin = {{4{c[3]}}, {4{c[0]}}};
      ioout = io & ~dirin;
      oe    = hsout | ioout;
      wmask = ioout & m0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R2 reset state
      chk("R2 pa_oe", {7'd0, pa_oe}, 0);
      chk("R2 pb_oe", {7'd0, pb_oe}, 0);
      chk("R2 pc_oe", pc_oe, 0);
      chk("R2 flags", {5'd0, inte_a1, inte_a2, inte_b}, 0);
      chk("R2 latches", pa_out | pb_out | pc_out, 0);
      chk("R1 idle oe", {7'd0, dout_oe}, 0);
      bus_rd(2'd3, r); chk("R2 ctl", r, 8'h9B);

      // R1 decode with all inputs
      pa_in = 8'h3C; pb_in = 8'hC3; pc_in = 8'h5E;
      bus_rd(2'd0, r); chk("R1 read A", r, 8'h3C);
      bus_rd(2'd1, r); chk("R1 read B", r, 8'hC3);
      bus_rd(2'd2, r); chk("R1 read C", r, 8'h5E);
      @(negedge clk); cs_n = 1; rd_n = 0;
      #1 chk("R1 no select", {7'd0, dout_oe}, 0);
      @(negedge clk); cs_n = 0; wr_n = 0;
      #1 chk("R1 write phase", {7'd0, dout_oe}, 0);
      @(negedge clk); rd_n = 1; cs_n = 1;
      repeat (5) @(negedge clk); wr_n = 1;
      repeat (5) @(negedge clk);

      // R3 R5 R6 mode 0 direction sweep
      for (int k = 0; k < 16; k++) begin
         logic [7:0] w, pv, bv;
         w = 8'h80 | (8'(k >> 3) << 4) | (8'((k >> 2) & 1) << 3) | (8'((k >> 1) & 1) << 1) | 8'(k & 1);
         bus_wr(2'd0, 8'hFF); bus_wr(2'd1, 8'hFF);
         bus_wr(2'd3, w);
         chk("R4 A cleared", pa_out, 0);
         chk("R4 B cleared", pb_out, 0);
         bus_rd(2'd3, r); chk("R3 readback", r, w);
         chk("R3 pa_oe", {7'd0, pa_oe}, {7'd0, ~w[4]});
         chk("R3 pb_oe", {7'd0, pb_oe}, {7'd0, ~w[1]});
         chk("R3 pc_oe", pc_oe, {{4{~w[3]}}, {4{~w[0]}}});
         pv = 8'(k * 17) ^ 8'h5A; bv = 8'(k * 29) ^ 8'hA7;
         bus_wr(2'd0, pv); bus_wr(2'd1, bv);
         chk("R5 A latch", pa_out, pv);
         chk("R5 B latch", pb_out, bv);
         bus_rd(2'd0, r); chk("R5 read A", r, w[4] ? pa_in : pv);
         bus_rd(2'd1, r); chk("R5 read B", r, w[1] ? pb_in : bv);
         bus_wr(2'd2, 8'hFF);
         chk("R6 C write mode0", pc_out, {{4{~w[3]}}, {4{~w[0]}}});
      end

      // R7 bit commands, all outputs, junk in bits 6:4
      bus_wr(2'd3, 8'h80);
      for (int i = 0; i < 8; i++) begin
         bus_wr(2'd3, 8'h50 | 8'(i << 1) | 8'h01);
         chk("R7 set line", pc_out, 8'((16'h1 << (i + 1)) - 1));
      end
      for (int i = 0; i < 8; i++) begin
         bus_wr(2'd3, 8'h70 | 8'(i << 1));
         chk("R7 clear line", pc_out, 8'hFF << (i + 1));
      end
      bus_wr(2'd3, 8'h89);
      bus_wr(2'd3, 8'h0D);
      chk("R7 input line untouched", pc_out, 0);
      pc_in = 8'h40;
      bus_rd(2'd2, r); chk("R9 input line reads pin", r & 8'h40, 8'h40);

      // R11 write timing and select
      bus_wr(2'd3, 8'h80);
      bus_wr(2'd0, 8'h11);
      @(negedge clk); addr = 0; din = 8'h77; cs_n = 0; wr_n = 0;
      repeat (5) @(negedge clk);
      #1 chk("R11 no effect while low", pa_out, 8'h11);
      wr_n = 1;
      @(negedge clk);
      #1 chk("R11 not after first edge", pa_out, 8'h11);
      repeat (2) @(negedge clk);
      #1 chk("R11 after third edge", pa_out, 8'h77);
      cs_n = 1;
      @(negedge clk); din = 8'h99; wr_n = 0;
      repeat (2) @(negedge clk); wr_n = 1;
      repeat (4) @(negedge clk);
      chk("R11 deselected write ignored", pa_out, 8'h77);

      // overlap: port C read open while a flag command commits
      bus_wr(2'd3, 8'h84);
      pc_in = 8'h00;
      @(negedge clk); addr = 3; din = 8'h05; cs_n = 0; wr_n = 0;
      repeat (2) @(negedge clk);
      wr_n = 1; addr = 2; rd_n = 0;
      @(negedge clk);
      #1 chk("R9 old flag in read", dout & 8'h04, 8'h00);
      repeat (2) @(negedge clk);
      #1 chk("R8 new flag in read", dout & 8'h04, 8'h04);
      @(negedge clk); rd_n = 1; cs_n = 1;
      chk("R8 inte_b", {7'd0, inte_b}, 1);

      // R10 R6 R7 R8 R9 R4 over every control word
      pc_in = 8'h00;
      for (int c = 0; c < 128; c++) begin
         logic [7:0] hsin, oe, wm, ioout, expf;
         roles(7'(c), hsin, oe, wm, ioout);
         bus_wr(2'd3, 8'h80 | 8'(c));
         chk("R4 C cleared", pc_out, 0);
         chk("R4 flags cleared", {5'd0, inte_a1, inte_a2, inte_b}, 0);
         chk("R10 pc_oe", pc_oe, oe);
         chk("R3 pa_oe", {7'd0, pa_oe}, {7'd0, ~c[4] & ~c[6]});
         bus_wr(2'd2, 8'hFF);
         chk("R6 C write", pc_out, wm);
         for (int i = 0; i < 8; i++) bus_wr(2'd3, 8'h60 | 8'(i << 1) | 8'h01);
         chk("R7 set all outputs", pc_out, oe);
         expf = {1'b0, hsin[6], 1'b0, hsin[4], 1'b0, hsin[2], 2'b00};
         chk("R8 flags", {1'b0, inte_a1, 1'b0, inte_a2, 1'b0, inte_b, 2'b00}, expf);
         bus_rd(2'd2, r); chk("R9 C read", r, ioout | hsin);
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule